// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a multi-channel event timer. The channel watches a free-running 64-bit main counter, which it takes as an input, and emits a one-cycle expiry pulse when the counter reaches the channel's comparator. A separate interrupt unit consumes the pulse. The channel can work in one-shot mode or periodic mode. In periodic mode the comparator moves forward by a hidden period register after each expiry. An optional 32-bit width confines every compare and add to the low halves.

Software reaches the channel through a small 32-bit register port with four word addresses. The port holds a configuration word, a read-only capability word, and the low and high halves of the comparator. The period register has no read path of its own. Software loads it through the comparator addresses while the channel is periodic.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, configuration reads 0, both comparator halves read 0xFFFFFFFF, the hidden period is 0, no wrap event is pending and `fire` is low.
- R2: Address 0 is the configuration word, with bit 0 channel enable, bit 1 periodic, bit 2 set-value and bit 3 32-bit width. Address 1 is the capability word. It always reads 0x3 (bit 0: periodic capable, bit 1: 64-bit capable) and ignores writes. Addresses 2 and 3 hold the low and high comparator halves. `rdata` follows `addr` combinationally.
- R3: Three events arm the channel. (a) A configuration write that takes the enable from 0 to 1 while `glb_en` is high. (b) A comparator write while the enable and `glb_en` are both high. (c) A rise of `glb_en` while the enable is set and the comparator is not all ones. After an arming event at clock edge E, the first comparison is made at edge E+2.
- R4: In one-shot mode an armed, enabled channel compares the count with the comparator at each edge. On the edge where they are equal it drives `fire` high for the following cycle and then disarms, so it fires only once.
- R5: In periodic mode with a nonzero period, each equality fires and adds the period to the comparator. The channel stays armed.
- R6: In periodic mode, when the comparator lags the count (signed difference below zero), the period is added once per edge with no pulse until the comparator catches up.
- R7: In periodic mode, a write to the low comparator half loads the period's low half. It loads the comparator's low half too only when set-value is 1. A write to the high half goes to the comparator when set-value is 1 and to the period otherwise. Any comparator write clears set-value.
- R8: A period write clears the period's top bit: bit 31 on a low-half write in 32-bit mode, and bit 63 on every high-half write.
- R9: A configuration write with bit 3 set clears the upper 32 bits of both the comparator and the period.
- R10: In 32-bit mode, equality and lag use only the low 32 bits of the count and comparator. The periodic add wraps modulo 2^32 and leaves the comparator's high half unchanged.
- R11: In 32-bit one-shot mode, a wrap event is pending when, at arming, the comparator's low half is below the count's low half. In that case the channel fires when the count's low half reads 0xFFFFFFFF, then fires again at the true match.
- R12: A configuration write that clears the enable disarms the channel, drops any pending wrap and suppresses the pulse that the same edge would produce. While `glb_en` is low nothing fires and the channel is disarmed.
- R13: A periodic channel whose period is 0 behaves as one-shot. It fires once and disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | 64 | Main counter value |
| glb_en | input | 1 | Global enable of the timer block |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address, for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| fire | output | 1 | One-cycle expiry pulse |

## Verification
The hardest situations to reach are the 32-bit wrap event and a periodic catch-up after missed periods. Reaching either by counting would take billions of cycles. Because the counter is a plain input, the stimulus jumps it to just below a 2^32 boundary, with a nonzero upper half, before arming the channel. It also leaps the count forward in the middle of a periodic run. The pulse counts of each phase are also compared with the number the requirements predict.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] count,
  input  logic        glb_en,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        fire
);
  localparam logic [31:0] CAPS = 32'h3;

  logic        en, per, sv, w32;
  logic        arm_q, armed, wrap, glb_q;
  logic [63:0] cmp, prd;

  logic cfg_wr, lo_wr, hi_wr, en_rise, en_fall, load_cmp;
  logic live, cycling, eq, behind, wrap_hit, match, advance, arm_d, fire_d;
  logic [63:0] d64;
  logic [31:0] d32;

  assign cfg_wr   = wr_en && addr == 2'd0;
  assign lo_wr    = wr_en && addr == 2'd2;
  assign hi_wr    = wr_en && addr == 2'd3;
  assign en_rise  = cfg_wr && wdata[0] && !en;
  assign en_fall  = cfg_wr && !wdata[0] && en;
  assign load_cmp = !per || sv;

  assign d64      = cmp - count;
  assign d32      = cmp[31:0] - count[31:0];
  assign eq       = w32 ? (d32 == 32'd0) : (d64 == 64'd0);
  assign behind   = w32 ? d32[31] : d64[63];
  assign live     = armed && en && glb_en;
  assign cycling  = per && (w32 ? (prd[31:0] != 32'd0) : (prd != 64'd0));
  assign wrap_hit = live && wrap && (count[31:0] == 32'hFFFF_FFFF);
  assign match    = live && !wrap && eq;
  assign advance  = live && !wrap && cycling && (eq || behind);
  assign fire_d   = (wrap_hit || match) && !en_fall;
  assign arm_d    = (en_rise && glb_en)
                 || ((lo_wr || hi_wr) && en && glb_en)
                 || (glb_en && !glb_q && en && cmp != '1);

  always_comb begin
    case (addr)
      2'd0:    rdata = {28'd0, w32, sv, per, en};
      2'd1:    rdata = CAPS;
      2'd2:    rdata = cmp[31:0];
      default: rdata = cmp[63:32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; per <= 1'b0; sv <= 1'b0; w32 <= 1'b0;
      arm_q <= 1'b0; armed <= 1'b0; wrap <= 1'b0; glb_q <= 1'b0;
      fire <= 1'b0;
      cmp <= '1;
      prd <= '0;
    end else begin
      glb_q <= glb_en;
      arm_q <= arm_d;
      fire  <= fire_d;

      if (en_fall || !glb_en) begin
        armed <= 1'b0;
        wrap  <= 1'b0;
      end else if (arm_q) begin
        armed <= 1'b1;
        wrap  <= w32 && !per && (cmp[31:0] < count[31:0]);
      end else begin
        if (wrap_hit) wrap <= 1'b0;
        if (match && !cycling) armed <= 1'b0;
      end

      if (advance) begin
        if (w32) cmp[31:0] <= cmp[31:0] + prd[31:0];
        else     cmp <= cmp + prd;
      end

      if (cfg_wr) begin
        en  <= wdata[0];
        per <= wdata[1];
        sv  <= wdata[2];
        w32 <= wdata[3];
        if (wdata[3]) begin
          cmp[63:32] <= '0;
          prd[63:32] <= '0;
        end
      end

      if (lo_wr) begin
        if (load_cmp) cmp[31:0] <= wdata;
        if (per) prd[31:0] <= {wdata[31] && !w32, wdata[30:0]};
        sv <= 1'b0;
      end

      if (hi_wr) begin
        if (load_cmp) cmp[63:32] <= wdata;
        else          prd[63:32] <= {1'b0, wdata[30:0]};
        sv <= 1'b0;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cmp == '1 && prd == '0 && !wrap && !fire)); // R1

  AST_FIRE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(en && glb_en && armed)); // R12

  AST_CATCHUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(live && behind && !wrap) |-> !fire); // R6

  AST_SETVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr[1]) |-> !sv); // R7

  AST_WIDTH_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 2'd0 && wdata[3]) |-> (cmp[63:32] == '0 && prd[63:32] == '0)); // R9
endmodule

// File: tb/sim_evt_cmp_channel.sv
`timescale 1ns/1ps
module sim_evt_cmp_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        glb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fire;

  evt_cmp_channel u0 (.clk(clk), .rst_n(rst_n), .count(count), .glb_en(glb_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .fire(fire));

  always #2.5 clk = ~clk;

  int    vec = 0, bad = 0, fires = 0, mark = 0;
  bit    chk_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  bit [63:0] ctr = '0;
  bit        inc = 1'b0;
  bit [1:0]  ra = 2'd0;

  // behavioural reference state
  bit [63:0] m_cmp, m_prd;
  bit m_en, m_per, m_sv, m_w32, m_armq, m_armed, m_wrap, m_fire, m_gq;

  always @(posedge clk) begin : ref_model
    bit cfgw, low, hiw, rise, fall, live, cyc, eq, beh, wh, mt, adv, armd, lc, old_armq;
    bit [63:0] d64;
    bit [31:0] d32;
    if (!rst_n) begin
      m_cmp = '1; m_prd = '0;
      {m_en, m_per, m_sv, m_w32, m_armq, m_armed, m_wrap, m_fire, m_gq} = '0;
    end else begin
      cfgw = wr_en && addr == 0;
      low  = wr_en && addr == 2;
      hiw  = wr_en && addr == 3;
      rise = cfgw && wdata[0] && !m_en;
      fall = cfgw && !wdata[0] && m_en;
      lc   = !m_per || m_sv;
      d64  = m_cmp - count;
      d32  = m_cmp[31:0] - count[31:0];
      eq   = m_w32 ? (d32 == 0) : (d64 == 0);
      beh  = m_w32 ? (int'(d32) < 0) : (longint'(d64) < 0);
      live = m_armed && m_en && glb_en;
      cyc  = m_per && (m_w32 ? m_prd[31:0] != 0 : m_prd != 0);
      wh   = live && m_wrap && count[31:0] == 32'hFFFF_FFFF;
      mt   = live && !m_wrap && eq;
      adv  = live && !m_wrap && cyc && (eq || beh);
      armd = (rise && glb_en) || ((low || hiw) && m_en && glb_en) ||
             (glb_en && !m_gq && m_en && m_cmp != '1);
      old_armq = m_armq;
      m_gq   = glb_en;
      m_armq = armd;
      m_fire = (wh || mt) && !fall;
      if (fall || !glb_en) begin m_armed = 0; m_wrap = 0; end
      else if (old_armq) begin
        m_armed = 1;
        m_wrap  = m_w32 && !m_per && (m_cmp[31:0] < count[31:0]);
      end else begin
        if (wh) m_wrap = 0;
        if (mt && !cyc) m_armed = 0;
      end
      if (adv) begin
        if (m_w32) m_cmp[31:0] = m_cmp[31:0] + m_prd[31:0];
        else m_cmp = m_cmp + m_prd;
      end
      if (cfgw) begin
        if (wdata[3]) begin m_cmp[63:32] = 0; m_prd[63:32] = 0; end
        {m_w32, m_sv, m_per, m_en} = wdata[3:0];
      end
      if (low) begin
        if (lc) m_cmp[31:0] = wdata;
        if (m_per) m_prd[31:0] = m_w32 ? (wdata & 32'h7FFF_FFFF) : wdata;
        m_sv = 0;
      end
      if (hiw) begin
        if (lc) m_cmp[63:32] = wdata;
        else m_prd[63:32] = wdata & 32'h7FFF_FFFF;
        m_sv = 0;
      end
    end
  end

  function automatic bit [31:0] exp_rd(bit [1:0] a);
    case (a)
      2'd0: return {28'd0, m_w32, m_sv, m_per, m_en};
      2'd1: return 32'h3;
      2'd2: return m_cmp[31:0];
      default: return m_cmp[63:32];
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (chk_on && !done) begin
      vec++;
      if (fire !== m_fire) begin
        bad++;
        $display("FAIL %s fire act=%0b exp=%0b at %0t", cur_req, fire, m_fire, $time);
      end
      vec++;
      if (rdata !== exp_rd(addr)) begin
        bad++;
        $display("FAIL %s rdata[%0d] act=%h exp=%h at %0t", cur_req, addr, rdata, exp_rd(addr), $time);
      end
      if (fire === 1'b1) fires++;
    end
  end

  task automatic step(bit we, bit [1:0] a, bit [31:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    if (inc) ctr = ctr + 1;
    count = ctr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, ra, 32'd0);
  endtask

  task automatic pulses(string req, int expn);
    vec++;
    if (fires - mark != expn) begin
      bad++;
      $display("FAIL %s pulse count act=%0d exp=%0d", req, fires - mark, expn);
    end
    mark = fires;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    @(posedge clk);
    chk_on = 1'b1;
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin ra = a[1:0]; idle(1); end

    cur_req = "R2";
    step(1, 1, 32'hFFFF_FFFF);
    ra = 1; idle(2);
    step(1, 0, 32'h6);
    ra = 0; idle(2);
    step(1, 0, 32'h0);

    cur_req = "R3";
    inc = 1; ctr = 0;
    step(1, 3, 32'd0);
    step(1, 2, 32'd40);
    step(1, 0, 32'h1);
    ra = 2; idle(5);
    pulses("R3", 0);
    glb_en = 1'b1;
    cur_req = "R4";
    idle(60);
    pulses("R4", 1);

    cur_req = "R7";
    step(1, 0, 32'h0);
    step(1, 0, 32'h6);
    step(1, 2, ctr[31:0] + 32'd30);
    ra = 2; idle(2);
    step(1, 2, 32'd8);
    idle(2);
    cur_req = "R8";
    step(1, 3, 32'h8000_0000);
    ra = 3; idle(2);
    cur_req = "R5";
    step(1, 0, 32'h3);
    ra = 2; idle(60);

    cur_req = "R6";
    ctr = ctr + 45;
    idle(25);

    cur_req = "R12";
    step(1, 0, 32'h2);
    mark = fires;
    idle(20);
    pulses("R12", 0);
    step(1, 0, 32'h3);
    idle(12);
    glb_en = 1'b0;
    mark = fires;
    idle(10);
    pulses("R12", 0);
    glb_en = 1'b1;
    idle(12);

    cur_req = "R13";
    step(1, 0, 32'h0);
    step(1, 0, 32'h6);
    step(1, 2, ctr[31:0] + 32'd20);
    step(1, 2, 32'd0);
    mark = fires;
    step(1, 0, 32'h3);
    idle(40);
    pulses("R13", 1);

    cur_req = "R9";
    step(1, 0, 32'h0);
    step(1, 3, 32'h0000_ABCD);
    ra = 3; idle(2);
    step(1, 0, 32'h8);
    idle(2);

    cur_req = "R10";
    step(1, 0, 32'hE);
    step(1, 2, 32'hFFFF_FFF8);
    cur_req = "R8";
    step(1, 2, 32'h8000_0004);
    cur_req = "R10";
    ctr = 64'h5_FFFF_FFF0;
    step(1, 0, 32'hB);
    ra = 2; idle(15);
    ra = 3; idle(15);

    cur_req = "R11";
    step(1, 0, 32'h8);
    step(1, 2, 32'h10);
    ctr = 64'h7_FFFF_FFE0;
    mark = fires;
    step(1, 0, 32'h9);
    ra = 2; idle(60);
    pulses("R11", 2);

    idle(3);
    finish_run();
  end
endmodule